// File: doc/BRIEF.md
# Four-Channel Serial DMA Register File

This block is the software-visible control plane of a four-channel serial DMA controller. A host reaches it over a plain 32-bit register bus with a write strobe and a combinational read path. For each channel it keeps four ring pointers: the start and end of the transmit ring, and the start and end of the receive ring. It also keeps a two-bit per-channel direction enable mask and a set of channel-active flags. Enable and disable commands written to a command register change those active flags. The commands use one of two opcode encodings, and the `chip_mode` input picks which one.

The ring engines sit outside this block. They read the pointers, the direction enables and the active flags from its outputs. They also get a one-cycle load strobe whenever software rewrites a ring start, so they can restart their current pointer. In return they send single-cycle transmit-done and receive-done pulses. Each pulse sets a pending flag. The flags are gathered into one status word and drive a level interrupt. Any write to the status word clears every pending flag at once.

Top module: `sdma_ctl_regs`

## Requirements
- R1: After reset all ring pointers, the enable mask, the channel-active flags and the pending flags are zero, so `irq` is low and every listed register reads zero.
- R2: Channel n (0..3) owns the byte window 0x100*(n+1) to 0x100*(n+1)+0xFF. Inside it, offset 0x80 holds TX start, 0x84 TX end, 0x88 RX start and 0x8C RX end. Each is a 32-bit register that reads back the last value written and appears on that channel's 32-bit slice of the matching ring output. Every other offset in the window reads zero.
- R3: A write to a channel's TX start (RX start) register pulses that channel's `tx_ptr_load` (`rx_ptr_load`) bit high for exactly the one cycle after the write edge. No other strobe bit rises, and writes to the end registers raise no strobe.
- R4: The enable mask at 0x14 keeps `reg_wdata[7:0]` and reads it back. Bit 2n is channel n's TX enable and bit 2n+1 is its RX enable. These drive `tx_enable[n]` and `rx_enable[n]`.
- R5: A pulse on `tx_evt[n]` sets TX pending for channel n, and a pulse on `rx_evt[n]` sets RX pending. A read of 0x0 returns TX pending n at bit n and RX pending n at bit 4+n. All other bits are zero.
- R6: Any write to 0x0, whatever the data, clears every pending flag. An event pulse in the same cycle as that write leaves its own flag set.
- R7: A write to 0x2C24 is a command. Bits 19:12 are the opcode and bits 1:0 select the channel. All other bits are ignored. With `chip_mode`=0, opcode 0x00 sets the selected channel active and opcode 0x10 clears it.
- R8: With `chip_mode`=1, opcode 0x00 sets the channel active, and opcodes 0x30 and 0x50 both clear it. Any opcode not listed for the current mode leaves every active flag unchanged. This includes 0x10 in mode 1, and 0x30 and 0x50 in mode 0.
- R9: A read of 0x2C2C returns 0x0000FFFF. Reads of any address not listed above, including the command register, return zero.
- R10: `irq` is high exactly when some channel has a pending TX flag and its TX enable set, or a pending RX flag and its RX enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_mode | input | 1 | Command encoding select (0 or 1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 14 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_evt | input | 4 | Per-channel transmit-done pulses |
| rx_evt | input | 4 | Per-channel receive-done pulses |
| tx_ring_start | output | 128 | TX ring start, channel n in bits 32n+31:32n |
| tx_ring_end | output | 128 | TX ring end, same packing |
| rx_ring_start | output | 128 | RX ring start, same packing |
| rx_ring_end | output | 128 | RX ring end, same packing |
| tx_ptr_load | output | 4 | One-cycle strobe after a TX start write |
| rx_ptr_load | output | 4 | One-cycle strobe after an RX start write |
| tx_enable | output | 4 | TX direction enable per channel |
| rx_enable | output | 4 | RX direction enable per channel |
| chan_active | output | 4 | Channel-active flags set by commands |
| irq | output | 1 | Level interrupt |

## Verification
The bench writes a distinct value into all sixteen ring registers and then reads every one back. A window decoded one slot off, or a pair of offsets swapped, would show up as aliased or misplaced values. Each opcode of interest is tried on every channel in both modes, starting from both the active and the inactive state. A decoder that honoured the other mode's disable code, or that reacted to an undefined opcode, would flip a flag the model keeps. Single events are swept over every channel, every direction and several enable masks to expose swapped TX/RX status bits or a wrong enable gate on `irq`. One clear is issued in the same cycle as an event; a design where the clear takes priority would lose that event.

// File: rtl/sdma_regs_pkg.sv
package sdma_regs_pkg;
  localparam logic [13:0] ADDR_STATUS = 14'h0000;
  localparam logic [13:0] ADDR_ENMASK = 14'h0014;
  localparam logic [13:0] ADDR_CMD    = 14'h2C24;
  localparam logic [13:0] ADDR_CMDRSP = 14'h2C2C;
  localparam logic [31:0] CMDRSP_VAL  = 32'h0000_FFFF;

  localparam logic [7:0] OFF_TX_START = 8'h80;
  localparam logic [7:0] OFF_TX_END   = 8'h84;
  localparam logic [7:0] OFF_RX_START = 8'h88;
  localparam logic [7:0] OFF_RX_END   = 8'h8C;

  typedef enum logic [1:0] {CMD_NOP, CMD_ON, CMD_OFF} cmd_act_e;

  function automatic cmd_act_e decode_opcode(input logic mode, input logic [7:0] op);
    cmd_act_e act;
    act = CMD_NOP;
    if (op == 8'h00) act = CMD_ON;
    else if (!mode && op == 8'h10) act = CMD_OFF;
    else if (mode && (op == 8'h30 || op == 8'h50)) act = CMD_OFF;
    return act;
  endfunction
endpackage

// File: rtl/sdma_ring_regs.sv
module sdma_ring_regs
  import sdma_regs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] tx_start,
  output logic [DW-1:0] tx_end,
  output logic [DW-1:0] rx_start,
  output logic [DW-1:0] rx_end,
  output logic          tx_load,
  output logic          rx_load
);
  logic [DW-1:0] txs_q, txe_q, rxs_q, rxe_q, txs_d, txe_d, rxs_d, rxe_d;
  logic          txl_q, rxl_q, txl_d, rxl_d;

  always_comb begin
    txs_d = txs_q;
    txe_d = txe_q;
    rxs_d = rxs_q;
    rxe_d = rxe_q;
    txl_d = 1'b0;
    rxl_d = 1'b0;
    if (wr_en) begin
      case (off)
        OFF_TX_START: begin txs_d = wdata; txl_d = 1'b1; end
        OFF_TX_END:   txe_d = wdata;
        OFF_RX_START: begin rxs_d = wdata; rxl_d = 1'b1; end
        OFF_RX_END:   rxe_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs_q <= '0;
      txe_q <= '0;
      rxs_q <= '0;
      rxe_q <= '0;
      txl_q <= 1'b0;
      rxl_q <= 1'b0;
    end else begin
      txs_q <= txs_d;
      txe_q <= txe_d;
      rxs_q <= rxs_d;
      rxe_q <= rxe_d;
      txl_q <= txl_d;
      rxl_q <= rxl_d;
    end
  end

  always_comb begin
    case (off)
      OFF_TX_START: rdata = txs_q;
      OFF_TX_END:   rdata = txe_q;
      OFF_RX_START: rdata = rxs_q;
      OFF_RX_END:   rdata = rxe_q;
      default:      rdata = '0;
    endcase
  end

  assign tx_start = txs_q;
  assign tx_end   = txe_q;
  assign rx_start = rxs_q;
  assign rx_end   = rxe_q;
  assign tx_load  = txl_q;
  assign rx_load  = rxl_q;

  // R3: a strobe always accompanies the freshly written start value
  p_tx_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (tx_start == $past(wdata)));
  p_rx_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |-> (rx_start == $past(wdata)));
  // R2: end registers hold when not addressed
  p_end_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(tx_end) && $stable(rx_end)));
endmodule

// File: rtl/sdma_cmd_ctl.sv
module sdma_cmd_ctl
  import sdma_regs_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_we,
  input  logic           mode,
  input  logic [7:0]     opcode,
  input  logic [1:0]     chan_sel,
  output logic [NCH-1:0] active
);
  logic [NCH-1:0] act_q, act_d;
  cmd_act_e       action;

  assign action = decode_opcode(mode, opcode);

  always_comb begin
    act_d = act_q;
    if (cmd_we) begin
      for (int i = 0; i < NCH; i++) begin
        if (chan_sel == 2'(i)) begin
          if (action == CMD_ON)  act_d[i] = 1'b1;
          if (action == CMD_OFF) act_d[i] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign active = act_q;

  // R8: opcodes outside both encodings change nothing
  p_unknown_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && opcode != 8'h00 && opcode != 8'h10 && opcode != 8'h30 && opcode != 8'h50)
      |=> $stable(active));
  p_no_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(active));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R7: enable opcode is common to both modes
    p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && opcode == 8'h00 && chan_sel == 2'(g)) |=> active[g]);
    // R8: mode 1 disable codes
    p_disable_m1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && mode && (opcode == 8'h30 || opcode == 8'h50) && chan_sel == 2'(g))
        |=> !active[g]);
  end
endmodule

// File: rtl/sdma_irq_status.sv
module sdma_irq_status #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   tx_evt,
  input  logic [NCH-1:0]   rx_evt,
  input  logic             clr,
  input  logic [NCH-1:0]   tx_en,
  input  logic [NCH-1:0]   rx_en,
  output logic [2*NCH-1:0] pend_word,
  output logic             irq
);
  logic [NCH-1:0] txp_q, rxp_q, txp_d, rxp_d;

  always_comb begin
    txp_d = clr ? '0 : txp_q;
    rxp_d = clr ? '0 : rxp_q;
    txp_d = txp_d | tx_evt;
    rxp_d = rxp_d | rx_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txp_q <= '0;
      rxp_q <= '0;
    end else begin
      txp_q <= txp_d;
      rxp_q <= rxp_d;
    end
  end

  assign pend_word = {rxp_q, txp_q};
  assign irq       = |((txp_q & tx_en) | (rxp_q & rx_en));

  // R6: a clear with no coincident event empties the status word
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(|tx_evt) && !(|rx_evt)) |=> (pend_word == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R5 / R6: an event always lands, even during a clear
    p_tx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_evt[g] |=> pend_word[g]);
    p_rx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt[g] |=> pend_word[NCH+g]);
  end
endmodule

// File: rtl/sdma_ctl_regs.sv
module sdma_ctl_regs
  import sdma_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_mode,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH-1:0]    tx_evt,
  input  logic [NCH-1:0]    rx_evt,
  output logic [NCH*DW-1:0] tx_ring_start,
  output logic [NCH*DW-1:0] tx_ring_end,
  output logic [NCH*DW-1:0] rx_ring_start,
  output logic [NCH*DW-1:0] rx_ring_end,
  output logic [NCH-1:0]    tx_ptr_load,
  output logic [NCH-1:0]    rx_ptr_load,
  output logic [NCH-1:0]    tx_enable,
  output logic [NCH-1:0]    rx_enable,
  output logic [NCH-1:0]    chan_active,
  output logic              irq
);
  localparam int WINW = AW - 8;
  localparam int MW   = 2 * NCH;

  logic [NCH-1:0]    win_hit;
  logic [DW-1:0]     chan_rd [NCH];
  logic [MW-1:0]     en_q, en_d;
  logic [MW-1:0]     pend_word;
  logic              hit_status, hit_mask, hit_cmd, hit_rsp;

  assign hit_status = (reg_addr == ADDR_STATUS);
  assign hit_mask   = (reg_addr == ADDR_ENMASK);
  assign hit_cmd    = (reg_addr == ADDR_CMD);
  assign hit_rsp    = (reg_addr == ADDR_CMDRSP);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign win_hit[g] = (reg_addr[AW-1:8] == WINW'(g + 1));

    sdma_ring_regs #(.DW(DW)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we && win_hit[g]),
      .off      (reg_addr[7:0]),
      .wdata    (reg_wdata),
      .rdata    (chan_rd[g]),
      .tx_start (tx_ring_start[g*DW +: DW]),
      .tx_end   (tx_ring_end[g*DW +: DW]),
      .rx_start (rx_ring_start[g*DW +: DW]),
      .rx_end   (rx_ring_end[g*DW +: DW]),
      .tx_load  (tx_ptr_load[g]),
      .rx_load  (rx_ptr_load[g])
    );

    assign tx_enable[g] = en_q[2*g];
    assign rx_enable[g] = en_q[2*g+1];
  end

  always_comb begin
    en_d = en_q;
    if (reg_we && hit_mask) en_d = reg_wdata[MW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  sdma_cmd_ctl #(.NCH(NCH)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (reg_we && hit_cmd),
    .mode     (chip_mode),
    .opcode   (reg_wdata[19:12]),
    .chan_sel (reg_wdata[1:0]),
    .active   (chan_active)
  );

  sdma_irq_status #(.NCH(NCH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_evt    (tx_evt),
    .rx_evt    (rx_evt),
    .clr       (reg_we && hit_status),
    .tx_en     (tx_enable),
    .rx_en     (rx_enable),
    .pend_word (pend_word),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_status) reg_rdata = DW'(pend_word);
    if (hit_mask)   reg_rdata = DW'(en_q);
    if (hit_rsp)    reg_rdata = CMDRSP_VAL;
    for (int i = 0; i < NCH; i++)
      if (win_hit[i]) reg_rdata = chan_rd[i];
  end

  // R10: no direction enabled means no interrupt
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable == '0 && rx_enable == '0) |-> !irq);
  // R4: the mask only moves on a write to its address
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && hit_mask) |=> ($stable(tx_enable) && $stable(rx_enable)));
  // R9: the response register is constant
  p_rsp_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rsp |-> (reg_rdata == 32'h0000_FFFF));
endmodule

// File: tb/sdma_ctl_regs_tb.sv
module sdma_ctl_regs_tb;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam time CYC = 5ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             chip_mode = 1'b0;
  logic             reg_we = 1'b0;
  logic [13:0]      reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [NCH-1:0]   tx_evt = '0, rx_evt = '0;
  logic [NCH*DW-1:0] tx_ring_start, tx_ring_end, rx_ring_start, rx_ring_end;
  logic [NCH-1:0]   tx_ptr_load, rx_ptr_load, tx_enable, rx_enable, chan_active;
  logic             irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [NCH-1:0] cap_txl, cap_rxl;
  logic [NCH-1:0] exp_act;

  always #(CYC/2) clk = ~clk;

  sdma_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .chip_mode(chip_mode), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt),
    .tx_ring_start(tx_ring_start), .tx_ring_end(tx_ring_end),
    .rx_ring_start(rx_ring_start), .rx_ring_end(rx_ring_end),
    .tx_ptr_load(tx_ptr_load), .rx_ptr_load(rx_ptr_load),
    .tx_enable(tx_enable), .rx_enable(rx_enable),
    .chan_active(chan_active), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // write; strobes are captured one cycle after the write edge
  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    cap_txl = tx_ptr_load; cap_rxl = rx_ptr_load;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ring_val(input int ch, input int r);
    return 32'h1357_0000 ^ (32'(ch) << 20) ^ (32'(r) << 8) ^ 32'(ch * 7 + r * 3 + 1);
  endfunction

  function automatic logic [7:0] ring_off(input int r);
    return 8'h80 + 8'(r * 4);
  endfunction

  function automatic int cmd_effect(input logic m, input logic [7:0] op);
    if (op == 8'h00) return 1;
    if (!m && op == 8'h10) return 2;
    if (m && (op == 8'h30 || op == 8'h50)) return 2;
    return 0;
  endfunction

  task automatic cmd(input int ch, input logic [7:0] op);
    int e;
    wr(14'h2C24, {12'hA5C, op, 10'h2A5, 2'(ch)});
    e = cmd_effect(chip_mode, op);
    if (e == 1) exp_act[ch] = 1'b1;
    if (e == 2) exp_act[ch] = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] r);
    @(negedge clk);
    tx_evt = t; rx_evt = r;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0;
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] ops [6];
    logic [7:0] masks [5];
    ops = '{8'h00, 8'h10, 8'h30, 8'h50, 8'h20, 8'hFF};
    masks = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h93};
    exp_act = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 active", 32'(chan_active), 0);
    chk("R1 ring", 32'(|{tx_ring_start, tx_ring_end, rx_ring_start, rx_ring_end}), 0);
    rd(14'h0000, d); chk("R1 status", d, 0);
    rd(14'h0014, d); chk("R1 mask", d, 0);

    // R2 / R3 ring registers
    for (int ch = 0; ch < NCH; ch++)
      for (int r = 0; r < 4; r++) begin
        wr(14'(256 * (ch + 1)) + 14'(ring_off(r)), ring_val(ch, r));
        chk("R3 tx strobe", 32'(cap_txl), (r == 0) ? (32'd1 << ch) : 0);
        chk("R3 rx strobe", 32'(cap_rxl), (r == 2) ? (32'd1 << ch) : 0);
        @(negedge clk);
        chk("R3 strobe single", 32'({tx_ptr_load, rx_ptr_load}), 0);
      end
    for (int ch = 0; ch < NCH; ch++) begin
      for (int r = 0; r < 4; r++) begin
        rd(14'(256 * (ch + 1)) + 14'(ring_off(r)), d);
        chk("R2 readback", d, ring_val(ch, r));
      end
      chk("R2 tx start out", tx_ring_start[ch*DW +: DW], ring_val(ch, 0));
      chk("R2 tx end out", tx_ring_end[ch*DW +: DW], ring_val(ch, 1));
      chk("R2 rx start out", rx_ring_start[ch*DW +: DW], ring_val(ch, 2));
      chk("R2 rx end out", rx_ring_end[ch*DW +: DW], ring_val(ch, 3));
      rd(14'(256 * (ch + 1)) + 14'h00, d); chk("R2 hole 00", d, 0);
      rd(14'(256 * (ch + 1)) + 14'h90, d); chk("R2 hole 90", d, 0);
      rd(14'(256 * (ch + 1)) + 14'hFC, d); chk("R2 hole FC", d, 0);
    end

    // R9 constants and unmapped
    rd(14'h2C2C, d); chk("R9 rsp", d, 32'h0000_FFFF);
    rd(14'h2C24, d); chk("R9 cmd reads 0", d, 0);
    rd(14'h0500, d); chk("R9 unmapped 500", d, 0);
    rd(14'h3FFC, d); chk("R9 unmapped 3FFC", d, 0);
    rd(14'h0018, d); chk("R9 unmapped 18", d, 0);

    // R7 / R8 commands in both modes, from both starting states
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); chip_mode = m[0];
      for (int ch = 0; ch < NCH; ch++)
        for (int k = 0; k < 6; k++) begin
          cmd(ch, 8'h00);
          cmd(ch, ops[k]);
          chk(m ? "R8 from active" : "R7 from active", 32'(chan_active), 32'(exp_act));
          cmd(ch, m ? 8'h30 : 8'h10);
          chk(m ? "R8 disable" : "R7 disable", 32'(chan_active), 32'(exp_act));
          cmd(ch, ops[k]);
          chk(m ? "R8 from idle" : "R7 from idle", 32'(chan_active), 32'(exp_act));
          cmd((ch + 1) % NCH, ops[k]);
          chk(m ? "R8 other chan" : "R7 other chan", 32'(chan_active), 32'(exp_act));
        end
    end

    // R4 / R5 / R10 single events under several masks
    for (int mi = 0; mi < 5; mi++) begin
      wr(14'h0014, {24'hFFFF00, masks[mi]});
      rd(14'h0014, d); chk("R4 mask readback", d, 32'(masks[mi]));
      for (int ch = 0; ch < NCH; ch++) begin
        chk("R4 tx_enable", 32'(tx_enable[ch]), 32'(masks[mi][2*ch]));
        chk("R4 rx_enable", 32'(rx_enable[ch]), 32'(masks[mi][2*ch+1]));
      end
      for (int ch = 0; ch < NCH; ch++)
        for (int dir = 0; dir < 2; dir++) begin
          wr(14'h0000, 32'h0);
          pulse(dir ? 4'b0 : 4'(1 << ch), dir ? 4'(1 << ch) : 4'b0);
          rd(14'h0000, d);
          chk("R5 status bit", d, 32'd1 << (dir * 4 + ch));
          chk("R10 irq", 32'(irq), 32'(masks[mi][2*ch+dir]));
        end
    end

    // R5 / R6 all events, clear, and clear racing an event
    wr(14'h0014, 32'hFF);
    pulse(4'hF, 4'hF);
    rd(14'h0000, d); chk("R5 all pending", d, 32'hFF);
    chk("R10 irq all", 32'(irq), 1);
    wr(14'h0000, 32'hDEAD_BEEF);
    rd(14'h0000, d); chk("R6 clear", d, 0);
    chk("R10 irq after clear", 32'(irq), 0);
    pulse(4'h3, 4'h8);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 14'h0000; reg_wdata = 32'h0; tx_evt = 4'h4;
    @(negedge clk);
    reg_we = 1'b0; tx_evt = '0;
    rd(14'h0000, d); chk("R6 event wins clear", d, 32'h04);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule